// File: doc/BRIEF.md
# Set Replacement Way Selector

This block names the way to evict when a set-associative cache with E ways per set has to bring in a new line. It does not store tags or data, and it does not decide hit or miss. It only keeps the bookkeeping that each replacement policy needs and presents a victim way for the set currently addressed.

Three policies are available behind a select input, and all three keep their state current at all times:

- a per-set rotating pointer (first in, first out);
- a single counter shared by all sets, which serves as a cheap pseudo-random choice;
- a full recency ordering per set (least recently used).

Switching the policy therefore takes effect at once and never starts from a cleared state.

The cache controller drives the set index and pulses the replace strobe when it fills a line in that set. It pulses the access strobe, together with the way touched, on every reference. A clock enable qualifies all state changes. The victim output is a purely combinational function of the stored state, the set index and the policy select.

Top module: `repl_way_sel`

## Requirements
- R1: After reset every set's rotating pointer is 0, the shared counter is 0, and every set's recency order runs from way 0 (least recent) to way E-1 (most recent), so the victim is way 0 under every policy.
- R2: With `policy` = 0 the victim is the addressed set's own pointer. The pointer steps by one, wrapping from E-1 to 0, on each enabled cycle with `repl_stb` high for that set; the pointers of the other sets do not change.
- R3: With `policy` = 1 the victim is the value of the single shared counter, whichever set is addressed.
- R4: The shared counter steps by one modulo E according to `rnd_sched`: 0 on every enabled cycle, 1 on enabled cycles with `acc_stb` high, 2 on enabled cycles with `repl_stb` high, and 3 never.
- R5: With `policy` = 2 or 3 the victim is the least recently accessed way of the addressed set. An enabled access makes `acc_way` the most recent way of that set, and the ways that were more recent than it each move one place toward least recent.
- R6: Changing `policy` clears no state. The state of every policy keeps updating whichever policy is selected.
- R7: While `en` is low, no pointer, counter or recency order changes, whatever the strobes do.
- R8: `victim_way` follows changes of `set_idx` and `policy` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Qualifies every state update in this cycle |
| set_idx | input | $clog2(SETS) | Set addressed by the strobes and by the victim output |
| repl_stb | input | 1 | A line of the addressed set is replaced this cycle |
| acc_stb | input | 1 | A reference to the addressed set occurs this cycle |
| acc_way | input | $clog2(WAYS) | Way touched by the reference |
| policy | input | 2 | 0 rotating, 1 shared counter, 2 or 3 recency |
| rnd_sched | input | 2 | Shared-counter advance schedule: 0 cycle, 1 reference, 2 replacement, 3 hold |
| victim_way | output | $clog2(WAYS) | Way to evict from the addressed set |

## Verification
The victim output is combinational, so a change of `set_idx` or `policy` is visible within the same cycle, while a strobe shows its effect only after the next rising edge. The bench therefore drives every input at the falling edge and compares `victim_way` a fraction of a nanosecond later against its own model of the state as it stood before the coming edge. It then advances the model to the post-edge state, ready for the next comparison. The recency model uses per-way access timestamps rather than a shifted list, so the least-recent choice is derived differently from the design.

// File: rtl/repl_pkg.sv
package repl_pkg;

  typedef enum logic [1:0] {
    POL_ROTATE  = 2'd0,
    POL_SHARED  = 2'd1,
    POL_RECENCY = 2'd2,
    POL_RECENT3 = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    SCH_CYCLE  = 2'd0,
    SCH_ACCESS = 2'd1,
    SCH_REPL   = 2'd2,
    SCH_HOLD   = 2'd3
  } sched_e;

endpackage

// File: rtl/repl_fifo_ptrs.sv
module repl_fifo_ptrs #(
  parameter int WAYS = 4,
  parameter int SETS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    repl_stb,
  input  logic [$clog2(SETS)-1:0] set_idx,
  output logic [$clog2(WAYS)-1:0] ptr_sel
);
  localparam int WB = $clog2(WAYS);

  function automatic logic [WB-1:0] wrap_inc(logic [WB-1:0] w);
    if (int'(w) == WAYS - 1) return '0;
    return w + 1'b1;
  endfunction

  logic [WB-1:0] ptr_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic step;
    assign step = en && repl_stb && (int'(set_idx) == s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q[s] <= '0;
      else if (step) ptr_q[s] <= wrap_inc(ptr_q[s]);
    end
  end

  assign ptr_sel = ptr_q[set_idx];
endmodule

// File: rtl/repl_rand_ctr.sv
module repl_rand_ctr
  import repl_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    acc_stb,
  input  logic                    repl_stb,
  input  sched_e                  sched,
  output logic [$clog2(WAYS)-1:0] value,
  output logic                    adv
);
  localparam int WB = $clog2(WAYS);

  function automatic logic wants_step(sched_e sc, logic acc, logic rep);
    case (sc)
      SCH_CYCLE:  return 1'b1;
      SCH_ACCESS: return acc;
      SCH_REPL:   return rep;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [WB-1:0] wrap_inc(logic [WB-1:0] w);
    if (int'(w) == WAYS - 1) return '0;
    return w + 1'b1;
  endfunction

  logic [WB-1:0] cnt_q;

  assign adv = en && wants_step(sched, acc_stb, repl_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= wrap_inc(cnt_q);
  end

  assign value = cnt_q;
endmodule

// File: rtl/repl_lru_order.sv
module repl_lru_order #(
  parameter int WAYS = 4,
  parameter int SETS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    acc_stb,
  input  logic [$clog2(WAYS)-1:0] acc_way,
  input  logic [$clog2(SETS)-1:0] set_idx,
  output logic [$clog2(WAYS)-1:0] oldest,
  output logic [$clog2(WAYS)-1:0] newest,
  output logic                    upd
);
  localparam int WB = $clog2(WAYS);
  typedef logic [WAYS-1:0][WB-1:0] ord_t;

  // slot 0 holds the least recent way, slot WAYS-1 the most recent
  function automatic ord_t promote(ord_t cur, logic [WB-1:0] w);
    ord_t nxt;
    logic found;
    nxt   = cur;
    found = 1'b0;
    for (int i = 0; i < WAYS - 1; i++) begin
      if (cur[i] == w) found = 1'b1;
      if (found) nxt[i] = cur[i+1];
    end
    nxt[WAYS-1] = w;
    return nxt;
  endfunction

  function automatic ord_t reset_order();
    ord_t r;
    for (int i = 0; i < WAYS; i++) r[i] = WB'(i);
    return r;
  endfunction

  ord_t ord_q [SETS];

  assign upd = en && acc_stb;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic touch;
    assign touch = upd && (int'(set_idx) == s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ord_q[s] <= reset_order();
      else if (touch) ord_q[s] <= promote(ord_q[s], acc_way);
    end
  end

  ord_t cur_ord;
  assign cur_ord = ord_q[set_idx];
  assign oldest  = cur_ord[0];
  assign newest  = cur_ord[WAYS-1];
endmodule

// File: rtl/repl_way_sel.sv
module repl_way_sel
  import repl_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [$clog2(SETS)-1:0] set_idx,
  input  logic                    repl_stb,
  input  logic                    acc_stb,
  input  logic [$clog2(WAYS)-1:0] acc_way,
  input  logic [1:0]              policy,
  input  logic [1:0]              rnd_sched,
  output logic [$clog2(WAYS)-1:0] victim_way
);
  localparam int WB = $clog2(WAYS);

  // named internal events, observed by the bound checker
  logic [WB-1:0] fifo_vict;
  logic          fifo_adv;
  logic [WB-1:0] rnd_val;
  logic          rnd_adv;
  logic [WB-1:0] lru_vict;
  logic [WB-1:0] lru_mru;
  logic          lru_upd;

  assign fifo_adv = en && repl_stb;

  repl_fifo_ptrs #(.WAYS(WAYS), .SETS(SETS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .en(en), .repl_stb(repl_stb),
    .set_idx(set_idx), .ptr_sel(fifo_vict)
  );

  repl_rand_ctr #(.WAYS(WAYS)) u_rand (
    .clk(clk), .rst_n(rst_n), .en(en), .acc_stb(acc_stb),
    .repl_stb(repl_stb), .sched(sched_e'(rnd_sched)),
    .value(rnd_val), .adv(rnd_adv)
  );

  repl_lru_order #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .en(en), .acc_stb(acc_stb),
    .acc_way(acc_way), .set_idx(set_idx),
    .oldest(lru_vict), .newest(lru_mru), .upd(lru_upd)
  );

  always_comb begin
    case (policy_e'(policy))
      POL_ROTATE: victim_way = fifo_vict;
      POL_SHARED: victim_way = rnd_val;
      default:    victim_way = lru_vict;
    endcase
  end
endmodule

// File: rtl/repl_way_sel_chk.sv
module repl_way_sel_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic [$clog2(SETS)-1:0] set_idx,
  input logic [$clog2(WAYS)-1:0] acc_way,
  input logic [$clog2(WAYS)-1:0] fifo_vict,
  input logic                    fifo_adv,
  input logic [$clog2(WAYS)-1:0] rnd_val,
  input logic                    rnd_adv,
  input logic [$clog2(WAYS)-1:0] lru_vict,
  input logic [$clog2(WAYS)-1:0] lru_mru,
  input logic                    lru_upd
);
  localparam int WB = $clog2(WAYS);

  a_r2_fifo_step: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_adv |=> (set_idx != $past(set_idx)) || (fifo_vict == WB'($past(fifo_vict) + 1'b1)));

  a_r4_rnd_step: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_adv |=> rnd_val == WB'($past(rnd_val) + 1'b1));

  a_r4_rnd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rnd_adv |=> $stable(rnd_val));

  a_r5_lru_mru: assert property (@(posedge clk) disable iff (!rst_n)
    lru_upd |=> (set_idx != $past(set_idx)) || (lru_mru == $past(acc_way)));

  a_r5_lru_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
    lru_upd |=> (set_idx != $past(set_idx)) || (lru_vict != $past(acc_way)));

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rnd_val) &&
            ((set_idx != $past(set_idx)) || ($stable(fifo_vict) && $stable(lru_vict))));
endmodule

bind repl_way_sel repl_way_sel_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .set_idx(set_idx), .acc_way(acc_way),
  .fifo_vict(fifo_vict), .fifo_adv(fifo_adv), .rnd_val(rnd_val),
  .rnd_adv(rnd_adv), .lru_vict(lru_vict), .lru_mru(lru_mru), .lru_upd(lru_upd)
);

// File: tb/sim_repl_way_sel.sv
`timescale 1ns/1ps
module sim_repl_way_sel;
  localparam int WAYS = 4;
  localparam int SETS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] set_idx = '0;
  logic       repl_stb = 1'b0;
  logic       acc_stb = 1'b0;
  logic [1:0] acc_way = '0;
  logic [1:0] policy = '0;
  logic [1:0] rnd_sched = '0;
  logic [1:0] victim_way;

  always #2 clk = ~clk;

  repl_way_sel #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .set_idx(set_idx), .repl_stb(repl_stb),
    .acc_stb(acc_stb), .acc_way(acc_way), .policy(policy),
    .rnd_sched(rnd_sched), .victim_way(victim_way)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model: rotating pointers, shared counter, per-way access stamps
  int fifo_m [SETS];
  int rnd_m;
  int stamp [SETS][WAYS];
  int tick;

  function automatic int expect_victim(int pol, int s);
    int best;
    if (pol == 0) return fifo_m[s];
    if (pol == 1) return rnd_m;
    best = 0;
    for (int w = 1; w < WAYS; w++) if (stamp[s][w] < stamp[s][best]) best = w;
    return best;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      fifo_m[s] = 0;
      for (int w = 0; w < WAYS; w++) stamp[s][w] = w;
    end
    rnd_m = 0;
    tick  = WAYS;
  endtask

  task automatic check(string tag);
    int e;
    e = expect_victim(int'(policy), int'(set_idx));
    n_run++;
    if (int'(victim_way) != e) begin
      n_fail++;
      $display("FAIL %s pol=%0d set=%0d victim=%0d expected=%0d",
               tag, policy, set_idx, victim_way, e);
    end
  endtask

  // drive at negedge, compare pre-edge state, then advance the model
  task automatic step(input logic [1:0] pol, input logic [1:0] sch, input int s,
                      input logic rp, input logic ac, input int wy,
                      input logic e_n, input string tag);
    bit go;
    @(negedge clk);
    policy = pol; rnd_sched = sch; set_idx = 3'(s);
    repl_stb = rp; acc_stb = ac; acc_way = 2'(wy); en = e_n;
    #0.5;
    check(tag);
    if (e_n) begin
      case (sch)
        2'd0: go = 1;
        2'd1: go = ac;
        2'd2: go = rp;
        default: go = 0;
      endcase
      if (go) rnd_m = (rnd_m + 1) % WAYS;
      if (rp) fifo_m[s] = (fifo_m[s] + 1) % WAYS;
      if (ac) begin tick++; stamp[s][wy] = tick; end
    end
  endtask

  task automatic peek(input logic [1:0] pol, input int s, input string tag);
    @(negedge clk);
    en = 1'b0; repl_stb = 1'b0; acc_stb = 1'b0;
    policy = pol; set_idx = 3'(s);
    #0.5;
    check(tag);
  endtask

  // fields: [10:9] policy, [8:7] schedule, [6:4] set, [3] repl, [2] access, [1:0] way
  localparam logic [10:0] VEC [0:15] = '{
    {2'd0, 2'd2, 3'd1, 1'b1, 1'b0, 2'd0},
    {2'd0, 2'd2, 3'd1, 1'b1, 1'b0, 2'd0},
    {2'd0, 2'd2, 3'd2, 1'b1, 1'b1, 2'd3},
    {2'd0, 2'd2, 3'd1, 1'b1, 1'b0, 2'd0},
    {2'd0, 2'd2, 3'd1, 1'b1, 1'b0, 2'd0},
    {2'd0, 2'd2, 3'd1, 1'b0, 1'b0, 2'd0},
    {2'd1, 2'd1, 3'd5, 1'b0, 1'b1, 2'd2},
    {2'd1, 2'd1, 3'd6, 1'b0, 1'b1, 2'd1},
    {2'd1, 2'd0, 3'd0, 1'b0, 1'b0, 2'd0},
    {2'd2, 2'd3, 3'd3, 1'b0, 1'b1, 2'd0},
    {2'd2, 2'd3, 3'd3, 1'b0, 1'b1, 2'd1},
    {2'd2, 2'd3, 3'd3, 1'b0, 1'b1, 2'd3},
    {2'd3, 2'd3, 3'd3, 1'b0, 1'b1, 2'd0},
    {2'd2, 2'd3, 3'd3, 1'b1, 1'b1, 2'd2},
    {2'd2, 2'd3, 3'd3, 1'b0, 1'b0, 2'd0},
    {2'd0, 2'd3, 3'd3, 1'b0, 1'b0, 2'd0}
  };

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every policy picks way 0 after reset, in several sets
    for (int s = 0; s < SETS; s += 3)
      for (int p = 0; p < 3; p++) peek(2'(p), s, "R1");

    // table walk, policy 0 -> R2, 1 -> R3, 2/3 -> R5; state spans policy changes (R6)
    for (int i = 0; i < 16; i++) begin
      logic [10:0] v;
      v = VEC[i];
      step(v[10:9], v[8:7], int'(v[6:4]), v[3], v[2], int'(v[1:0]), 1'b1,
           v[10:9] == 2'd0 ? "R2" : (v[10:9] == 2'd1 ? "R3" : "R5"));
    end

    // R2: set 1 replaced, set 0 and set 2 pointers stay independent
    peek(2'd0, 1, "R2 wrap");
    peek(2'd0, 0, "R2 other set");
    peek(2'd0, 2, "R2 other set");

    // R3: shared counter identical for all sets
    for (int s = 0; s < SETS; s++) peek(2'd1, s, "R3 any set");

    // R4: each schedule
    for (int k = 0; k < 3; k++) step(2'd1, 2'd0, 4, 1'b0, 1'b0, 0, 1'b1, "R4 cycle");
    step(2'd1, 2'd1, 4, 1'b1, 1'b0, 0, 1'b1, "R4 access sched ignores repl");
    step(2'd1, 2'd1, 4, 1'b0, 1'b1, 1, 1'b1, "R4 access");
    step(2'd1, 2'd2, 4, 1'b0, 1'b1, 2, 1'b1, "R4 repl sched ignores access");
    step(2'd1, 2'd2, 4, 1'b1, 1'b0, 0, 1'b1, "R4 repl");
    step(2'd1, 2'd3, 4, 1'b1, 1'b1, 3, 1'b1, "R4 hold");
    peek(2'd1, 4, "R4 hold");

    // R5: middle way promotion order in set 7
    step(2'd2, 2'd3, 7, 1'b0, 1'b1, 1, 1'b1, "R5");
    step(2'd2, 2'd3, 7, 1'b0, 1'b1, 0, 1'b1, "R5");
    step(2'd2, 2'd3, 7, 1'b0, 1'b1, 2, 1'b1, "R5");
    peek(2'd2, 7, "R5 oldest is 3");
    step(2'd2, 2'd3, 7, 1'b0, 1'b1, 3, 1'b1, "R5");
    peek(2'd2, 7, "R5 oldest is 1");

    // R6: state built under one policy still visible after switching
    peek(2'd0, 1, "R6");
    peek(2'd3, 3, "R6");
    peek(2'd1, 0, "R6");

    // R7: strobes with en low change nothing
    step(2'd0, 2'd0, 5, 1'b1, 1'b1, 3, 1'b0, "R7");
    step(2'd0, 2'd0, 5, 1'b1, 1'b1, 3, 1'b0, "R7");
    for (int p = 0; p < 3; p++) peek(2'(p), 5, "R7");

    // R8: victim follows set_idx within the cycle
    @(negedge clk);
    en = 1'b0; policy = 2'd0; set_idx = 3'd1;
    #0.5 check("R8");
    set_idx = 3'd2;
    #0.5 check("R8");
    policy = 2'd2; set_idx = 3'd7;
    #0.5 check("R8");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule